// File: doc/BRIEF.md
# Next-PC Unit with Conditional and Unconditional Branch

This block holds the fetch address of a 64-bit machine whose instructions are all 32 bits long. On every clock edge where it is not stalled, it loads one of three candidates into its program-counter register. The first is the sequential address, which is the current PC plus 4. The second is a zero-conditional branch target, which uses a 19-bit word offset. The third is an always-taken branch target, which uses a 26-bit word offset. Both targets are computed relative to the PC of the branch instruction itself.

The decode stage supplies the current instruction word and two branch controls. The ALU supplies its zero flag. The registered PC is the output, and it feeds instruction fetch directly. A reset loads a configurable start address. A stall input freezes the PC in place.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals the parameter `RESET_PC`, whose default is 0. The reset takes effect without waiting for a clock edge.
- R2: On a rising edge with `stall_i` high, `pc_o` keeps its value, whatever the branch controls are.
- R3: On a rising edge with `stall_i` low and both branch controls low, `pc_o` becomes `pc_o + 4`.
- R4: On a rising edge with `stall_i` low, `cond_br_i` high, `zero_i` high and `uncond_br_i` low, `pc_o` becomes `pc_o + (sext(instr_i[23:5]) << 2)`. The sum is based on the branch's own PC, not on PC+4.
- R5: On a rising edge with `stall_i` low, `cond_br_i` high, `zero_i` low and `uncond_br_i` low, `pc_o` becomes `pc_o + 4`.
- R6: On a rising edge with `stall_i` low and `uncond_br_i` high, `pc_o` becomes `pc_o + (sext(instr_i[25:0]) << 2)`. The value of `zero_i` has no effect.
- R7: When both `cond_br_i` and `uncond_br_i` are high, the unconditional target of R6 is taken, and the 19-bit field is ignored.
- R8: Offsets are two's complement. A set top bit in the offset field (bit 23 for the conditional branch, bit 25 for the unconditional branch) moves the PC backwards.
- R9: All PC arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| stall_i | input | 1 | High to hold the PC |
| instr_i | input | 32 | Instruction word at the current PC |
| cond_br_i | input | 1 | Instruction is a branch taken on a zero flag |
| uncond_br_i | input | 1 | Instruction is an always-taken branch |
| zero_i | input | 1 | ALU zero flag for the current instruction |
| pc_o | output | 64 | Registered fetch address |

## Verification
The bench builds the unit with `RESET_PC` set to `64'hFFFF_FFFF_FFFF_FF00`, just below the top of the address space. The offset widths and field positions stay at their defaults. This start address puts the modulo-2^64 wrap of R9 within reach of a single short forward jump. It also makes the reset value distinguishable from an all-zero register. Backward offsets and the case with both branch controls high are driven from there, so every target sum lands on an address that is easy to predict.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Source chosen for the next fetch address
  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_COND = 2'd1,
    NPC_UNC  = 2'd2
  } npc_src_e;
endpackage

// File: rtl/npc_offset.sv
// Sign-extends a word offset field and scales it to a byte offset.
module npc_offset #(
  parameter int FIELD_W = 19,
  parameter int SHIFT   = 2,
  parameter int OUT_W   = 64
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [OUT_W-1:0]   byte_off_o
);
  localparam int EXT_W = OUT_W - FIELD_W - SHIFT;

  generate
    if (SHIFT > 0) begin : g_scaled
      assign byte_off_o = {{EXT_W{field_i[FIELD_W-1]}}, field_i, {SHIFT{1'b0}}};
    end else begin : g_plain
      assign byte_off_o = {{EXT_W{field_i[FIELD_W-1]}}, field_i};
    end
  endgenerate
endmodule

// File: rtl/npc_decide.sv
// Chooses the next-PC source from the branch controls and the zero flag.
module npc_decide
  import npc_pkg::*;
(
  input  logic     cond_br_i,
  input  logic     uncond_br_i,
  input  logic     zero_i,
  output npc_src_e src_o
);
  always_comb begin
    if (uncond_br_i)              src_o = NPC_UNC;
    else if (cond_br_i && zero_i) src_o = NPC_COND;
    else                          src_o = NPC_SEQ;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              PC_W         = 64,
  parameter int              INSTR_W      = 32,
  parameter int              INSTR_BYTES  = 4,
  parameter int              COND_OFF_W   = 19,
  parameter int              COND_OFF_LSB = 5,
  parameter int              UNC_OFF_W    = 26,
  parameter logic [PC_W-1:0] RESET_PC     = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               cond_br_i,
  input  logic               uncond_br_i,
  input  logic               zero_i,
  output logic [PC_W-1:0]    pc_o
);
  localparam int SHIFT    = $clog2(INSTR_BYTES);
  localparam int COND_MSB = COND_OFF_LSB + COND_OFF_W - 1;
  localparam int USED_MSB = (COND_MSB > UNC_OFF_W - 1) ? COND_MSB : UNC_OFF_W - 1;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] cond_off, unc_off;
  logic [PC_W-1:0] seq_pc, cond_pc, unc_pc, pc_next;
  npc_src_e        src;

  // Opcode bits are decoded elsewhere
  logic unused_hi;
  generate
    if (USED_MSB < INSTR_W - 1) begin : g_hi
      assign unused_hi = ^instr_i[INSTR_W-1:USED_MSB+1];
    end else begin : g_nohi
      assign unused_hi = 1'b0;
    end
  endgenerate

  npc_offset #(.FIELD_W(COND_OFF_W), .SHIFT(SHIFT), .OUT_W(PC_W)) u_cond_off (
    .field_i    (instr_i[COND_MSB:COND_OFF_LSB]),
    .byte_off_o (cond_off)
  );

  npc_offset #(.FIELD_W(UNC_OFF_W), .SHIFT(SHIFT), .OUT_W(PC_W)) u_unc_off (
    .field_i    (instr_i[UNC_OFF_W-1:0]),
    .byte_off_o (unc_off)
  );

  npc_decide u_decide (
    .cond_br_i   (cond_br_i),
    .uncond_br_i (uncond_br_i),
    .zero_i      (zero_i),
    .src_o       (src)
  );

  // Candidate addresses, all based on the current PC
  assign seq_pc  = pc_q + PC_W'(INSTR_BYTES);
  assign cond_pc = pc_q + cond_off;
  assign unc_pc  = pc_q + unc_off;

  always_comb begin
    unique case (src)
      NPC_COND: pc_next = cond_pc;
      NPC_UNC:  pc_next = unc_pc;
      default:  pc_next = seq_pc;
    endcase
  end

  // Next-state with explicit enable
  always_comb begin
    pc_d = pc_q;
    if (!stall_i) pc_d = pc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int              PC_W         = 64,
  parameter int              INSTR_W      = 32,
  parameter int              INSTR_BYTES  = 4,
  parameter int              COND_OFF_W   = 19,
  parameter int              COND_OFF_LSB = 5,
  parameter int              UNC_OFF_W    = 26,
  parameter logic [PC_W-1:0] RESET_PC     = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stall_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               cond_br_i,
  input logic               uncond_br_i,
  input logic               zero_i,
  input logic [PC_W-1:0]    pc_o
);
  localparam int SHIFT = $clog2(INSTR_BYTES);
  localparam int CMSB  = COND_OFF_LSB + COND_OFF_W - 1;

  logic [PC_W-1:0] c_off, u_off;
  assign c_off = {{(PC_W-COND_OFF_W-SHIFT){instr_i[CMSB]}}, instr_i[CMSB:COND_OFF_LSB], {SHIFT{1'b0}}};
  assign u_off = {{(PC_W-UNC_OFF_W-SHIFT){instr_i[UNC_OFF_W-1]}}, instr_i[UNC_OFF_W-1:0], {SHIFT{1'b0}}};

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_o == RESET_PC);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_o));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !cond_br_i && !uncond_br_i) |=> pc_o == $past(pc_o) + PC_W'(INSTR_BYTES));

  // R4
  cond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && cond_br_i && zero_i && !uncond_br_i) |=> pc_o == $past(pc_o) + $past(c_off));

  // R5
  cond_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && cond_br_i && !zero_i && !uncond_br_i) |=> pc_o == $past(pc_o) + PC_W'(INSTR_BYTES));

  // R6 R7
  uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && uncond_br_i) |=> pc_o == $past(pc_o) + $past(u_off));
endmodule

bind npc_unit npc_unit_chk #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .INSTR_BYTES(INSTR_BYTES),
  .COND_OFF_W(COND_OFF_W), .COND_OFF_LSB(COND_OFF_LSB),
  .UNC_OFF_W(UNC_OFF_W), .RESET_PC(RESET_PC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .instr_i(instr_i),
  .cond_br_i(cond_br_i), .uncond_br_i(uncond_br_i), .zero_i(zero_i),
  .pc_o(pc_o)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  localparam logic [63:0] RST_PC = 64'hFFFF_FFFF_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_i;
  logic [31:0] instr_i;
  logic        cond_br_i, uncond_br_i, zero_i;
  logic [63:0] pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  npc_unit #(.RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .instr_i(instr_i),
    .cond_br_i(cond_br_i), .uncond_br_i(uncond_br_i), .zero_i(zero_i),
    .pc_o(pc_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [31:0] cbz_word(input logic [18:0] off);
    return {8'hB4, off, 5'd3};
  endfunction

  function automatic logic [31:0] b_word(input logic [25:0] off);
    return {6'b000101, off};
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (pc_o !== exp) begin
      failures++;
      $display("FAIL %s pc_o=%h expected=%h", req, pc_o, exp);
    end
  endtask

  // Drive at a falling edge, step one rising edge, sample at the next falling edge
  task automatic step(input logic s, input logic [31:0] ins, input logic c,
                      input logic u, input logic z);
    stall_i = s; instr_i = ins; cond_br_i = c; uncond_br_i = u; zero_i = z;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    #1;
    check("R1", RST_PC);
    @(negedge clk);
    check("R1", RST_PC);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    #2 rst_n = 1'b0;  // asynchronous, mid-cycle
    #1 check("R1", RST_PC);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", RST_PC);
  endtask

  task automatic t_seq;
    logic [63:0] p;
    p = pc_o;
    step(1'b0, 32'h8B02_0020, 1'b0, 1'b0, 1'b1);
    check("R3", p + 64'd4);
    step(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    check("R3", p + 64'd8);
  endtask

  task automatic t_stall;
    logic [63:0] p;
    p = pc_o;
    step(1'b1, b_word(26'd100), 1'b0, 1'b1, 1'b0);
    check("R2", p);
    step(1'b1, cbz_word(19'd7), 1'b1, 1'b0, 1'b1);
    check("R2", p);
  endtask

  task automatic t_cond;
    logic [63:0] p;
    p = pc_o;
    step(1'b0, cbz_word(19'd16), 1'b1, 1'b0, 1'b1);
    check("R4", p + 64'd64);
    p = pc_o;
    step(1'b0, cbz_word(19'd16), 1'b1, 1'b0, 1'b0);
    check("R5", p + 64'd4);
  endtask

  task automatic t_uncond;
    logic [63:0] p;
    p = pc_o;
    step(1'b0, b_word(26'd5), 1'b0, 1'b1, 1'b0);
    check("R6", p + 64'd20);
    p = pc_o;
    step(1'b0, b_word(26'd5), 1'b0, 1'b1, 1'b1);
    check("R6", p + 64'd20);
  endtask

  task automatic t_both;
    logic [63:0] p;
    p = pc_o;
    // bits 25:0 = 26'h0000_100 (word 256); bits 23:5 = 8 (word 8)
    step(1'b0, {6'd0, 26'h100}, 1'b1, 1'b1, 1'b1);
    check("R7", p + 64'd1024);
  endtask

  task automatic t_negative;
    logic [63:0] p;
    p = pc_o;
    step(1'b0, cbz_word(19'h7FFFE), 1'b1, 1'b0, 1'b1);  // -2 words
    check("R8", p - 64'd8);
    p = pc_o;
    step(1'b0, b_word(26'h3FFFFFC), 1'b0, 1'b1, 1'b0);  // -4 words
    check("R8", p - 64'd16);
  endtask

  task automatic t_wrap;
    do_reset();
    step(1'b0, b_word(26'd64), 1'b0, 1'b1, 1'b0);  // +256 bytes
    check("R9", 64'h0);
    do_reset();
    step(1'b0, cbz_word(19'd63), 1'b1, 1'b0, 1'b1);  // +252
    check("R9", 64'hFFFF_FFFF_FFFF_FFFC);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    check("R9", 64'h0);
  endtask

  initial begin
    stall_i = 1'b0; instr_i = '0; cond_br_i = 1'b0; uncond_br_i = 1'b0; zero_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    t_seq();
    t_stall();
    t_cond();
    t_uncond();
    t_both();
    t_negative();
    t_reset();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule